// File: doc/BRIEF.md
# Fan Speed Ramp Generator

This block produces the 8-bit code for a fan-speed DAC. Software writes a target speed into a target register. It writes a small control register to choose between two modes. With ramping off, the target drives the DAC code directly. With ramping on, an up/down counter sits between target and output and moves one count per tick toward the target. This keeps the fan from changing speed abruptly, which reduces acoustic noise and wear.

The tick comes from a prescaler on the system clock. Four rates are available, from one step per second up to sixteen steps per second. A thermal override input bypasses everything and forces full scale at once. Writing a new target while a ramp is in progress simply redirects the counter, and it may count the other way. Clearing the enable snaps the output to the target.

Top module: `fan_ramp_gen`

## Requirements
- R1: After reset, the target register, the counter and the control register are all zero, so the output code is 0x00 and ramping is off.
- R2: While ramping is off and the override is low, a target written on `tgt_wr` appears on `dac_code` in the cycle after the write edge.
- R3: Enabling ramping (control bit 0) preloads the counter with the current target, so the output holds its value until a different target is written.
- R4: Control bits 2:1 select the tick period: 00 gives CLK_HZ cycles (1 Hz), 01 gives CLK_HZ/4 (4 Hz), 10 gives CLK_HZ/8 (8 Hz) and 11 gives CLK_HZ/16 (16 Hz). A write that changes this field restarts the prescaler, so the first step lands exactly one period after that write edge.
- R5: While ramping, each tick moves the counter by exactly one toward the target. It never passes the target and stays put once equal. No change happens between ticks.
- R6: A target written mid-ramp on the other side of the counter reverses the counting direction at the next tick.
- R7: While ramping is on, `dac_code` is the counter value rather than the target.
- R8: When `force_full` is high, `dac_code` is 0xFF in the same cycle, whatever the mode or counter state.
- R9: Clearing the enable bit mid-ramp makes `dac_code` equal the target in the cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_wr | input | 1 | Write strobe for the target register |
| tgt_wdata | input | CODE_W | Target speed code to write |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 3 | Bit 0 enables ramping; bits 2:1 select the rate |
| force_full | input | 1 | Over-temperature override, forces full scale |
| dac_code | output | CODE_W | Code driven to the fan DAC |

## Verification
Assertions check properties that must hold on every cycle:
- The counter moves by at most one count per cycle.
- The counter stays still when it equals the target and never crosses it.
- It is equal to the target on the cycle ramping becomes active.
- Ticks never come back to back, and no tick follows a rate change at once.
- The override always yields full scale.
- Leaving ramp mode shows the target.

Only the bench scenarios can show the rest:
- The actual spacing of steps for each of the four rates.
- Where a ramp stops.
- A reversal after a mid-ramp target write.
- Direct pass-through of targets while ramping is off.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // Step-rate selector, taken from control bits 2:1
  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4HZ  = 2'b01,
    RATE_8HZ  = 2'b10,
    RATE_16HZ = 2'b11
  } rate_e;

  // Control register layout: bit 0 enable, bits 2:1 rate
  typedef struct packed {
    rate_e rate;
    logic  en;
  } ramp_ctl_t;

  localparam int unsigned CTL_W = $bits(ramp_ctl_t);

endpackage

// File: rtl/fsr_tick_gen.sv
module fsr_tick_gen
  import fsr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  restart_i,
  input  rate_e rate_i,
  output logic  tick_o
);

  localparam int unsigned CW       = $clog2(CLK_HZ);
  localparam int unsigned TERM_1   = CLK_HZ - 1;
  localparam int unsigned TERM_4   = CLK_HZ / 4 - 1;
  localparam int unsigned TERM_8   = CLK_HZ / 8 - 1;
  localparam int unsigned TERM_16  = CLK_HZ / 16 - 1;

  logic [CW-1:0] cnt_q, cnt_d, term;

  always_comb begin
    unique case (rate_i)
      RATE_1HZ:  term = CW'(TERM_1);
      RATE_4HZ:  term = CW'(TERM_4);
      RATE_8HZ:  term = CW'(TERM_8);
      default:   term = CW'(TERM_16);
    endcase
  end

  assign tick_o = run_i && (cnt_q == term);

  always_comb begin
    if (!run_i || restart_i || tick_o) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: periods are at least two cycles, so ticks are isolated pulses
  a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R4: a rate change restarts the period, so no tick follows it directly
  a_r4_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick_o);

endmodule

// File: rtl/fsr_stepper.sv
module fsr_stepper #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] tgt_i,
  input  logic [W-1:0] tgt_next_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  // While idle the counter shadows the target, which is the preload
  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                        cnt_d = tgt_next_i;
    else if (tick_i && cnt_q < tgt_i) cnt_d = cnt_q + 1'b1;
    else if (tick_i && cnt_q > tgt_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: ramping starts from the target, so the output does not jump
  a_r3_preload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> cnt_q == tgt_i);

  // R5: a single-count change at most per cycle
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |->
      (cnt_q == $past(cnt_q) || cnt_q == W'($past(cnt_q) + 1'b1) ||
       cnt_q == W'($past(cnt_q) - 1'b1)));

  // R5: parked at the target
  a_r5_hold_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(cnt_q) == $past(tgt_i)) |-> $stable(cnt_q));

  // R5: never passes the target from below or above
  a_r5_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(cnt_q) < $past(tgt_i)) |-> cnt_q <= $past(tgt_i));
  a_r5_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(cnt_q) > $past(tgt_i)) |-> cnt_q >= $past(tgt_i));

  // R5: nothing moves between ticks
  a_r5_idle_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !$past(tick_i)) |-> $stable(cnt_q));

endmodule

// File: rtl/fsr_out_sel.sv
module fsr_out_sel #(
  parameter int unsigned W = 8
) (
  input  logic         ramp_en_i,
  input  logic         force_i,
  input  logic [W-1:0] tgt_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] code_o
);

  always_comb begin
    if (force_i)        code_o = '1;
    else if (ramp_en_i) code_o = cnt_i;
    else                code_o = tgt_i;
  end

endmodule

// File: rtl/fan_ramp_gen.sv
module fan_ramp_gen
  import fsr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              force_full,
  output logic [CODE_W-1:0] dac_code
);

  logic [CODE_W-1:0] tgt_q, tgt_d;
  ramp_ctl_t         ctl_q, ctl_d, ctl_in;
  logic              restart, tick;
  logic [CODE_W-1:0] cnt;

  assign ctl_in = ramp_ctl_t'(ctl_wdata);

  always_comb begin
    tgt_d = tgt_q;
    if (tgt_wr) tgt_d = tgt_wdata;
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ctl_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      ctl_q <= ctl_d;
    end
  end

  assign restart = ctl_wr && (ctl_in.rate != ctl_q.rate);

  fsr_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ctl_q.en),
    .restart_i (restart),
    .rate_i    (ctl_q.rate),
    .tick_o    (tick)
  );

  fsr_stepper #(.W(CODE_W)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (ctl_q.en),
    .tick_i     (tick),
    .tgt_i      (tgt_q),
    .tgt_next_i (tgt_d),
    .cnt_o      (cnt)
  );

  fsr_out_sel #(.W(CODE_W)) u_sel (
    .ramp_en_i (ctl_q.en),
    .force_i   (force_full),
    .tgt_i     (tgt_q),
    .cnt_i     (cnt),
    .code_o    (dac_code)
  );

  // R8: override reaches full scale in the same cycle
  a_r8_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    force_full |-> dac_code == {CODE_W{1'b1}});

  // R9: leaving ramp mode exposes the target at once
  a_r9_exit_jump: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_q.en) && !force_full) |-> dac_code == tgt_q);

endmodule

// File: tb/fan_ramp_gen_tb.sv
module fan_ramp_gen_tb;

  localparam int unsigned CLK_HZ = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tgt_wr;
  logic [7:0] tgt_wdata;
  logic       ctl_wr;
  logic [2:0] ctl_wdata;
  logic       force_full;
  logic [7:0] dac_code;

  int nchk = 0;
  int nerr = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  fan_ramp_gen #(.CLK_HZ(CLK_HZ), .CODE_W(8)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_wr     (tgt_wr),
    .tgt_wdata  (tgt_wdata),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .force_full (force_full),
    .dac_code   (dac_code)
  );

  typedef struct packed {
    logic       frc;
    logic [7:0] tgt;
    logic [7:0] exp;
  } vec_t;

  // Ramping off: direct pass-through or override
  localparam vec_t VECS [6] = '{
    '{frc: 1'b0, tgt: 8'h00, exp: 8'h00},
    '{frc: 1'b0, tgt: 8'h5A, exp: 8'h5A},
    '{frc: 1'b1, tgt: 8'h12, exp: 8'hFF},
    '{frc: 1'b0, tgt: 8'hFF, exp: 8'hFF},
    '{frc: 1'b1, tgt: 8'h00, exp: 8'hFF},
    '{frc: 1'b0, tgt: 8'h80, exp: 8'h80}
  };

  task automatic chk(input string req, input logic [7:0] exp);
    nchk++;
    if (dac_code !== exp) begin
      nerr++;
      $display("FAIL %s: dac_code=%02h expected %02h at %0t", req, dac_code, exp, $time);
    end
  endtask

  // All drive tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tgt_write(input logic [7:0] v);
    tgt_wr = 1'b1;
    tgt_wdata = v;
    step(1);
    tgt_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic en, input logic [1:0] rate);
    ctl_wr = 1'b1;
    ctl_wdata = {rate, en};
    step(1);
    ctl_wr = 1'b0;
  endtask

  function automatic int period(input logic [1:0] rate);
    case (rate)
      2'b00:   return CLK_HZ;
      2'b01:   return CLK_HZ / 4;
      2'b10:   return CLK_HZ / 8;
      default: return CLK_HZ / 16;
    endcase
  endfunction

  function automatic logic [7:0] toward(input logic [7:0] s, input logic [7:0] t, input int k);
    int d;
    d = (t > s) ? int'(t - s) : int'(s - t);
    if (k > d) k = d;
    return (t > s) ? 8'(s + k) : 8'(s - k);
  endfunction

  // Rate change at edge C restarts the prescaler; target write at C+1;
  // steps land at C+P*k
  task automatic ramp_run(input logic [1:0] rate, input logic [7:0] s,
                          input logic [7:0] t, input int nk);
    int p;
    p = period(rate);
    ctl_write(1'b1, rate ^ 2'b01);
    ctl_write(1'b1, rate);
    tgt_write(t);
    step(p - 2);
    chk("R4 no step before period", s);
    step(1);
    chk("R4/R5 first step at period", toward(s, t, 1));
    for (int k = 2; k <= nk; k++) begin
      step(p);
      chk("R5/R7 ramp step", toward(s, t, k));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tgt_wr = 1'b0;
    tgt_wdata = '0;
    ctl_wr = 1'b0;
    ctl_wdata = '0;
    force_full = 1'b0;
    step(3);
    chk("R1 reset output", 8'h00);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", 8'h00);

    // R2 and R8 through the vector table
    foreach (VECS[i]) begin
      force_full = VECS[i].frc;
      tgt_write(VECS[i].tgt);
      chk(VECS[i].frc ? "R8 override" : "R2 direct write", VECS[i].exp);
    end
    force_full = 1'b0;

    // R3: enable preloads, output holds
    tgt_write(8'h40);
    chk("R2 direct write", 8'h40);
    ctl_write(1'b1, 2'b11);
    step(12);
    chk("R3 hold after enable", 8'h40);

    // R4/R5: each rate, up and down, stop at target
    ramp_run(2'b11, 8'h40, 8'h46, 8);
    ramp_run(2'b00, 8'h46, 8'h44, 3);
    ramp_run(2'b01, 8'h44, 8'h47, 3);
    ramp_run(2'b10, 8'h47, 8'h40, 3);

    // R6: reverse mid-ramp (rate 10, ticks every 8 from restart edge C;
    // now after C+24 at 0x44 heading down)
    tgt_write(8'h50);
    step(6);
    chk("R6 before reverse step", 8'h44);
    step(1);
    chk("R6 reversed upward", 8'h45);
    step(8);
    chk("R6 continues upward", 8'h46);

    // R8 while ramping, then release back to the counter (R7)
    force_full = 1'b1;
    #1;
    chk("R8 override mid-ramp", 8'hFF);
    force_full = 1'b0;
    #1;
    chk("R7 counter after release", 8'h46);

    // R9: disable mid-ramp
    ctl_write(1'b0, 2'b10);
    chk("R9 jump to target", 8'h50);
    tgt_write(8'h21);
    chk("R2 direct after disable", 8'h21);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog (all requirements): cycles=100000 expected completion earlier");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule